// File: doc/BRIEF.md
# Programmable Baud Tick Divider

This block divides the reference clock to produce a one-clock enable pulse at sixteen times the serial bit rate. A host sets the 16-bit divisor through a byte-wide write port, one byte at a time. The divisor is the reference clock frequency divided by sixteen times the wanted bit rate. For example, a 3.072 MHz reference with divisor 20 gives a 9600 bit/s rate. An 8 MHz reference with divisor 52 gives close to 9600 bit/s.

A second output pulses once for every sixteen fast ticks, on the same cycle as the sixteenth one. Any divisor write restarts the internal down-counter at once from the full new divisor, so a new rate applies without waiting for the old period to finish. Divisor zero is not a supported rate. With divisor zero the block stays silent and does not free-run.

Top module: `baud_gen`

## Requirements
- R1: After reset both tick outputs are low, the divisor is zero and no tick appears until a nonzero divisor is written.
- R2: A write with `wrAddr`=0 replaces divisor bits 7:0 and a write with `wrAddr`=1 replaces bits 15:8. The other byte keeps its value.
- R3: After any divisor write that leaves a divisor D of 1 or more, the first `tick16` appears D cycles after the write edge. The write edge itself counts as cycle 1.
- R4: With no further writes, `tick16` repeats with a period of exactly D cycles.
- R5: With divisor 1, `tick16` is high on every cycle.
- R6: With divisor 0, `tick16` and `tick1` stay low.
- R7: For D of 2 or more, `tick16` is high for exactly one cycle at a time.
- R8: `tick1` is high only together with `tick16`. It marks every 16th `tick16` counted from the last divisor write, so it first appears 16·D cycles after the write and then repeats every 16·D cycles.
- R9: A write during a count discards the remaining count. The next tick follows the new divisor as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Divisor byte write strobe, one cycle per write |
| wrAddr | input | 1 | Byte select: 0 low byte, 1 high byte |
| wrData | input | 8 | Byte to write |
| tick16 | output | 1 | One-cycle pulse at sixteen times the bit rate |
| tick1 | output | 1 | One-cycle pulse at the bit rate |

## Verification
The assertions assume that `wrEn` is low while reset is asserted. They also assume that the divisor changes only through the write port, with `wrAddr` selecting one of the two existing bytes. The bench drives every write for exactly one cycle from the falling edge and holds all write inputs idle during reset. This keeps the stimulus inside those assumptions. Tick spacing is measured in cycles from each write edge, for divisors 0, 1, 2, 7, 259 and 258, for a write in the middle of a count, and for the slower tick.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 2;
  localparam int DIV_W   = BYTE_W * N_BYTES;
  localparam int SEL_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
  localparam int SUB_W   = 4;

  typedef struct packed {
    logic [N_BYTES-1:0] loadByte;
    logic               restart;
  } ctrl_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
(
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrAddr,
  output ctrl_t            strb
);
  always_comb begin
    strb.loadByte = '0;
    strb.restart  = wrEn;
    for (int b = 0; b < N_BYTES; b++) begin
      if (wrEn && (wrAddr == SEL_W'(b))) strb.loadByte[b] = 1'b1;
    end
  end
endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [DIV_W-1:0]  divQ,
  output logic              tick16,
  output logic              tick1
);
  logic [DIV_W-1:0] divNext;
  logic [DIV_W-1:0] cnt;
  logic [SUB_W-1:0] sub;

  // merge the incoming byte into the held divisor
  always_comb begin
    divNext = divQ;
    for (int b = 0; b < N_BYTES; b++) begin
      if (strb.loadByte[b]) divNext[b*BYTE_W +: BYTE_W] = wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) divQ <= '0;
    else       divQ <= divNext;
  end

  // down-counter: terminal count at one, parked at zero
  always_ff @(posedge clk) begin
    if (!rstN)                     cnt <= '0;
    else if (strb.restart)         cnt <= divNext;
    else if (cnt == DIV_W'(1))     cnt <= divQ;
    else if (cnt != '0)            cnt <= cnt - 1'b1;
  end

  assign tick16 = (cnt == DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)             sub <= '0;
    else if (strb.restart) sub <= '0;
    else if (tick16)       sub <= sub + 1'b1;
  end

  assign tick1 = tick16 && (sub == '1);
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic              tick16,
  output logic              tick1
);
  ctrl_t            strb;
  logic [DIV_W-1:0] divQ;

  baud_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strb   (strb)
  );

  baud_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .divQ   (divQ),
    .tick16 (tick16),
    .tick1  (tick1)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk
  import baud_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [DIV_W-1:0] divisor,
  input logic             tick16,
  input logic             tick1
);
  assert_zero_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |-> (!tick16 && !tick1));

  assert_div_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == DIV_W'(1)) |-> tick16);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tick16 && !wrEn && divisor > DIV_W'(1)) |=> !tick16);

  assert_write_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && divisor > DIV_W'(1)) |-> !tick16);

  assert_slow_inside_fast_R8: assert property (@(posedge clk) disable iff (!rstN)
    tick1 |-> tick16);
endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .divisor (divQ),
  .tick16  (tick16),
  .tick1   (tick1)
);

// File: tb/baud_gen_bench.sv
module baud_gen_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [0:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       tick16, tick1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_gen u_baud_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .tick16(tick16), .tick1(tick1)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setDiv(input int d);
    wr(1'b1, d[15:8]);
    wr(1'b0, d[7:0]);
  endtask

  // index of first tick16 starting at the current sample (index 1)
  task automatic firstTick(input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      if (tick16) begin k = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic nextTick(input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (tick16) begin k = i; break; end
    end
  endtask

  task automatic test_reset();
    int seen = 0;
    check("R1 tick16 at reset", tick16, 0);
    check("R1 tick1 at reset", tick1, 0);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tick16 || tick1) seen++;
    end
    check("R1 no ticks before first write", seen, 0);
  endtask

  task automatic test_period(input int d);
    int k;
    setDiv(d);
    firstTick(d + 20, k);
    check("R3 first tick after write", k, d);
    @(negedge clk);
    check("R7 pulse one cycle wide", tick16, 0);
    nextTick(d + 20, k);
    check("R4 steady period", k + 1, d);
  endtask

  task automatic test_div1();
    int hi = 0;
    setDiv(1);
    for (int i = 0; i < 20; i++) begin
      if (tick16) hi++;
      @(negedge clk);
    end
    check("R5 tick every cycle", hi, 20);
  endtask

  task automatic test_zero();
    int seen = 0;
    setDiv(0);
    for (int i = 0; i < 150; i++) begin
      if (tick16 || tick1) seen++;
      @(negedge clk);
    end
    check("R6 silent at zero", seen, 0);
  endtask

  task automatic test_bytes();
    int k;
    setDiv(16'h0103);
    firstTick(400, k);
    check("R2 both bytes form divisor", k, 259);
    wr(1'b0, 8'h02);
    firstTick(400, k);
    check("R2 high byte kept on low write", k, 258);
  endtask

  task automatic test_midwrite();
    int k;
    setDiv(100);
    repeat (30) @(negedge clk);
    wr(1'b0, 8'd5);
    firstTick(200, k);
    check("R9 mid-count write restarts", k, 5);
  endtask

  task automatic test_tick1();
    int k = 0;
    int bad = 0;
    setDiv(3);
    for (int i = 1; i <= 200; i++) begin
      if (tick1) begin k = i; break; end
      @(negedge clk);
    end
    check("R8 first slow tick", k, 48);
    check("R8 slow tick with fast tick", tick16, 1);
    k = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (tick1 && !tick16) bad++;
      if (tick1) begin k = i; break; end
    end
    check("R8 slow tick period", k, 48);
    check("R8 slow only with fast", bad, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_period(2);
    test_period(7);
    test_div1();
    test_zero();
    test_bytes();
    test_midwrite();
    test_tick1();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule